// File: doc/BRIEF.md
# Instruction Sequence Controller

This block steps every instruction through a small set of control states: a fetch state, an optional index modification state, and up to three execution states. The timing generator raises a one-cycle end-of-state strobe when the work of the current state is finished. On that strobe the controller picks the next state from the current state, a decoded opcode class vector and a flag that says the instruction names a non-zero index field. Between strobes the state does not change.

The current state leaves the block as a registered one-hot vector of five bits. The datapath uses these bits to enable the work that belongs to each state. A registered pulse, `fetch_go`, marks the first cycle of each new fetch. Each listed opcode class has its own bit of `op_cls`, and at most one bit is expected to be set. With no bit set the instruction takes the plain path: fetch, then the main execution state, then fetch again.

Top module: `instr_seq_ctl`

## Requirements
- R1: A synchronous reset, active high, puts the controller in the fetch state (`seq_st` = 5'b00001) and drives `fetch_go` low.
- R2: In a cycle where `step` is low, `seq_st` keeps its value and `fetch_go` is low at the next edge, whatever `op_cls` and `idx_nz` hold.
- R3: From fetch, a strobe with only the short-branch class bit set (`op_cls` bit 0: execute, unconditional branch, the two bit-test branches) and `idx_nz` low keeps the controller in fetch (bit 0).
- R4: From fetch, a strobe goes to the index state (bit 1) when `idx_nz` is high, or when the class is transfer-on-index-high (bit 1), store-index (bit 2) or decrement-memory-test (bit 3). This takes priority over R3.
- R5: From fetch, any other strobe goes to execution state 3 (bit 2) for multiply (bit 4), divide (bit 5), timer in/out (bit 6) or store-Q (bit 7). Every other class goes to the main execution state 4 (bit 3).
- R6: From the index state, a strobe returns to fetch for the short-branch and transfer-on-index-high classes. Store-index and the R5 classes go to state 3. Everything else goes to state 4.
- R7: From state 3, a strobe always goes to state 4.
- R8: From state 4, a strobe goes to state 5 (bit 4) for multiply, divide, timer, store-Q, load-Q (bit 8) and generic-3 (bit 9). Any other class returns to fetch.
- R9: From state 5, a strobe always returns to fetch.
- R10: `fetch_go` is high for exactly the one cycle that follows a strobe whose next state is fetch. At all other times it is low.
- R11: `seq_st` always has exactly one bit set. An internal state code outside the five legal values returns to fetch on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | End-of-state strobe from the timing generator |
| op_cls | input | 10 | Decoded opcode class, one bit per class, at most one bit set |
| idx_nz | input | 1 | Index field of the instruction is non-zero |
| seq_st | output | 5 | One-hot current state: bit 0 fetch, bit 1 index, bits 2 to 4 execution states 3 to 5 |
| fetch_go | output | 1 | One-cycle pulse at the start of each new fetch |

## Verification
Both results are registered once. A strobe presented before a clock edge changes `seq_st` and `fetch_go` at that same edge, so both are due one cycle after the stimulus. The bench drives inputs on the falling edge and compares both outputs a short delay after the next rising edge. A reference function written from the requirements gives the expected values at that moment. Idle cycles with random class and index inputs are checked the same way, which confirms that both outputs hold or stay low between strobes.

// File: rtl/isc_pkg.sv
package isc_pkg;

  localparam int NST   = 5;
  localparam int STW   = 3;
  localparam int CLS_W = 10;

  // class bit positions inside op_cls
  localparam int CB_SHORT = 0;  // execute, unconditional and bit-test branches
  localparam int CB_TXH   = 1;  // transfer on index high
  localparam int CB_STX   = 2;  // store index
  localparam int CB_DMT   = 3;  // decrement memory and test
  localparam int CB_MPY   = 4;
  localparam int CB_DVD   = 5;
  localparam int CB_TIMR  = 6;  // timer in / timer out
  localparam int CB_STQ   = 7;
  localparam int CB_LDQ   = 8;
  localparam int CB_GEN3  = 9;

  typedef enum logic [STW-1:0] {
    ST_FETCH = 3'd0,
    ST_INDEX = 3'd1,
    ST_EX3   = 3'd2,
    ST_EX4   = 3'd3,
    ST_EX5   = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic to_index;    // fetch must pass through the index state
    logic done_fetch;  // instruction completes inside fetch
    logic done_index;  // instruction completes inside the index state
    logic use_ex3;     // execution needs state 3
    logic use_ex5;     // execution needs state 5
  } route_t;

  function automatic logic [CLS_W-1:0] bit_of(input int pos);
    logic [CLS_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/isc_route.sv
module isc_route
  import isc_pkg::*;
#(
  parameter int W = CLS_W,
  parameter logic [W-1:0] M_IDX  = bit_of(CB_TXH) | bit_of(CB_STX) | bit_of(CB_DMT),
  parameter logic [W-1:0] M_SHRT = bit_of(CB_SHORT),
  parameter logic [W-1:0] M_IDXD = bit_of(CB_SHORT) | bit_of(CB_TXH),
  parameter logic [W-1:0] M_EX3  = bit_of(CB_STX) | bit_of(CB_MPY) | bit_of(CB_DVD)
                                 | bit_of(CB_TIMR) | bit_of(CB_STQ),
  parameter logic [W-1:0] M_EX5  = bit_of(CB_MPY) | bit_of(CB_DVD) | bit_of(CB_TIMR)
                                 | bit_of(CB_STQ) | bit_of(CB_LDQ) | bit_of(CB_GEN3)
) (
  input  logic [W-1:0] cls,
  input  logic         idx,
  output route_t       rt
);

  logic [W-1:0] hit_idx, hit_shrt, hit_idxd, hit_ex3, hit_ex5;

  // per-class membership terms, one slice per class bit
  for (genvar i = 0; i < W; i++) begin : g_cls
    assign hit_idx[i]  = cls[i] & M_IDX[i];
    assign hit_shrt[i] = cls[i] & M_SHRT[i];
    assign hit_idxd[i] = cls[i] & M_IDXD[i];
    assign hit_ex3[i]  = cls[i] & M_EX3[i];
    assign hit_ex5[i]  = cls[i] & M_EX5[i];
  end

  always_comb begin
    rt.to_index   = idx | (|hit_idx);
    rt.done_fetch = |hit_shrt;
    rt.done_index = |hit_idxd;
    rt.use_ex3    = |hit_ex3;
    rt.use_ex5    = |hit_ex5;
  end

endmodule

// File: rtl/isc_next.sv
module isc_next
  import isc_pkg::*;
(
  input  seq_st_e cur,
  input  route_t  rt,
  output seq_st_e nxt
);

  seq_st_e exec_entry;

  // first execution state once fetch and indexing are behind us
  always_comb begin
    exec_entry = rt.use_ex3 ? ST_EX3 : ST_EX4;
  end

  always_comb begin
    unique case (cur)
      ST_FETCH: begin
        if (rt.to_index)        nxt = ST_INDEX;
        else if (rt.done_fetch) nxt = ST_FETCH;
        else                    nxt = exec_entry;
      end
      ST_INDEX: begin
        if (rt.done_index) nxt = ST_FETCH;
        else               nxt = exec_entry;
      end
      ST_EX3:  nxt = ST_EX4;
      ST_EX4:  nxt = rt.use_ex5 ? ST_EX5 : ST_FETCH;
      ST_EX5:  nxt = ST_FETCH;
      default: nxt = ST_FETCH;  // unused codes recover to fetch
    endcase
  end

endmodule

// File: rtl/isc_state_reg.sv
module isc_state_reg
  import isc_pkg::*;
#(
  parameter int N = NST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  seq_st_e      nxt,
  output seq_st_e      cur,
  output logic [N-1:0] st_oh,
  output logic         go
);

  logic [N-1:0] nxt_oh;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign nxt_oh[i] = (32'(nxt) == i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_FETCH;
      st_oh <= N'(1);
      go    <= 1'b0;
    end else if (step) begin
      cur   <= nxt;
      st_oh <= nxt_oh;
      go    <= (nxt == ST_FETCH);
    end else begin
      go    <= 1'b0;
    end
  end

endmodule

// File: rtl/instr_seq_ctl.sv
module instr_seq_ctl
  import isc_pkg::*;
#(
  parameter int CW = CLS_W,
  parameter int SN = NST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] op_cls,
  input  logic          idx_nz,
  output logic [SN-1:0] seq_st,
  output logic          fetch_go
);

  route_t  rt;
  seq_st_e cur, nxt;

  isc_route #(.W(CW)) u_route (
    .cls (op_cls),
    .idx (idx_nz),
    .rt  (rt)
  );

  isc_next u_next (
    .cur (cur),
    .rt  (rt),
    .nxt (nxt)
  );

  isc_state_reg #(.N(SN)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .nxt   (nxt),
    .cur   (cur),
    .st_oh (seq_st),
    .go    (fetch_go)
  );

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int CW = 10,
  parameter int SN = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic [CW-1:0] op_cls,
  input logic          idx_nz,
  input logic [SN-1:0] seq_st,
  input logic          fetch_go
);

  AST_RESET_FETCH: assert property (@(posedge clk)
    rst |=> (seq_st == SN'(1)) && !fetch_go);  // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(seq_st) && !fetch_go);  // R2

  AST_SHORT_STAY: assert property (@(posedge clk) disable iff (rst)
    (step && seq_st[0] && !idx_nz && op_cls == CW'(1)) |=> seq_st[0] && fetch_go);  // R3

  AST_INDEX_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (step && seq_st[0] && idx_nz) |=> seq_st[1]);  // R4

  AST_EX3_TO_EX4: assert property (@(posedge clk) disable iff (rst)
    (step && seq_st[2]) |=> seq_st[3]);  // R7

  AST_EX5_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (step && seq_st[4]) |=> seq_st[0] && fetch_go);  // R9

  AST_GO_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_go |-> seq_st[0] && $past(step));  // R10

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones(seq_st) == 1);  // R11

endmodule

bind instr_seq_ctl isc_checker #(.CW(CW), .SN(SN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step     (step),
  .op_cls   (op_cls),
  .idx_nz   (idx_nz),
  .seq_st   (seq_st),
  .fetch_go (fetch_go)
);

// File: tb/sim_instr_seq_ctl.sv
module sim_instr_seq_ctl;

  localparam int CLK_P = 10;
  localparam int CW    = 10;
  localparam int SN    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step = 1'b0;
  logic [CW-1:0] op_cls = '0;
  logic          idx_nz = 1'b0;
  logic [SN-1:0] seq_st;
  logic          fetch_go;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_st = 1;   // expected state number 1..5
  bit exp_go = 1'b0;

  instr_seq_ctl u0 (
    .clk(clk), .rst(rst), .step(step), .op_cls(op_cls),
    .idx_nz(idx_nz), .seq_st(seq_st), .fetch_go(fetch_go)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference transition written from the requirements
  function automatic int ref_next(int s, logic [CW-1:0] c, bit ix);
    bit ex3 = c[2] | c[4] | c[5] | c[6] | c[7];
    bit ex5 = c[4] | c[5] | c[6] | c[7] | c[8] | c[9];
    case (s)
      1: begin
        if (ix || c[1] || c[2] || c[3]) return 2;   // R4
        if (c[0]) return 1;                          // R3
        return ex3 ? 3 : 4;                          // R5
      end
      2: begin
        if (c[0] || c[1]) return 1;                  // R6
        return ex3 ? 3 : 4;
      end
      3: return 4;                                   // R7
      4: return ex5 ? 5 : 1;                         // R8
      default: return 1;                             // R9
    endcase
  endfunction

  function automatic string tag_of(int s, logic [CW-1:0] c, bit ix);
    case (s)
      1: return (ix || c[1] || c[2] || c[3]) ? "R4" : (c[0] ? "R3" : "R5");
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_out(string tag);
    logic [SN-1:0] e_oh = SN'(1) << (exp_st - 1);
    total++;
    if (seq_st !== e_oh || $countones(seq_st) != 1) begin
      bad++;
      $display("FAIL %s seq_st actual=%b expected=%b (R11 one-hot)", tag, seq_st, e_oh);
    end
    total++;
    if (fetch_go !== exp_go) begin
      bad++;
      $display("FAIL R10/%s fetch_go actual=%b expected=%b", tag, fetch_go, exp_go);
    end
  endtask

  task automatic tick(bit s, logic [CW-1:0] c, bit ix);
    string tg;
    @(negedge clk);
    step = s; op_cls = c; idx_nz = ix;
    @(posedge clk);
    if (s) begin
      tg     = tag_of(exp_st, c, ix);
      exp_st = ref_next(exp_st, c, ix);
      exp_go = (exp_st == 1);
    end else begin
      tg     = "R2";
      exp_go = 1'b0;
    end
    #1;
    check_out(tg);
  endtask

  function automatic logic [CW-1:0] rand_cls();
    int r = int'($urandom % 11);
    return (r < CW) ? (CW'(1) << r) : '0;
  endfunction

  task automatic run_instr(logic [CW-1:0] c, bit ix, bit gaps);
    int n = 0;
    do begin
      if (gaps) begin
        int g = int'($urandom % 3);
        for (int k = 0; k < g; k++) tick(1'b0, rand_cls(), 1'($urandom % 2));
      end
      tick(1'b1, c, ix);
      n++;
    end while (exp_st != 1 && n < 8);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    exp_st = 1; exp_go = 1'b0;
    check_out("R1");
    rst = 1'b0;
    // R2: idle cycles with noisy inputs
    for (int k = 0; k < 4; k++) tick(1'b0, rand_cls(), 1'b1);
    // directed corner cases
    run_instr(CW'(1) << 0, 1'b0, 1'b0);  // R3 short branch stays in fetch
    run_instr(CW'(1) << 0, 1'b1, 1'b0);  // R4/R6 indexed short branch
    run_instr(CW'(1) << 1, 1'b0, 1'b0);  // R4/R6 transfer on index high
    run_instr(CW'(1) << 2, 1'b0, 1'b0);  // R4/R6/R7 store index via 2,3,4
    run_instr(CW'(1) << 3, 1'b0, 1'b0);  // R4/R6 decrement test 1,2,4
    run_instr(CW'(1) << 4, 1'b0, 1'b1);  // R5/R7/R8/R9 multiply full path
    run_instr(CW'(1) << 6, 1'b1, 1'b0);  // R6 indexed timer
    run_instr(CW'(1) << 8, 1'b0, 1'b0);  // R8 load-Q 1,4,5
    run_instr(CW'(1) << 9, 1'b0, 1'b1);  // R8 generic-3
    run_instr('0, 1'b0, 1'b0);           // R5/R8 plain 1,4
    // mid-instruction reset returns to fetch: R1
    tick(1'b1, CW'(1) << 5, 1'b0);
    @(negedge clk); rst = 1'b1; step = 1'b0;
    @(posedge clk); #1;
    exp_st = 1; exp_go = 1'b0;
    check_out("R1");
    @(negedge clk); rst = 1'b0;
    // constrained random instruction stream
    for (int k = 0; k < 400; k++)
      run_instr(rand_cls(), 1'($urandom % 4 == 0), 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule